// File: doc/BRIEF.md
# Converter Result Output Port with Byte Steering

This block sits between a converter's result register and its parallel data pins. It holds the most recent conversion word, captured on a one-cycle load strobe. It presents that word on a row of output lanes, and each lane has its own output-enable. The pad drivers are outside the block. They take the lane values and the enables and either drive or float each pin.

Two read styles share the same pins. In the full-width style, the whole word appears at once in natural bit order. In the split style, a host on a narrow bus reads the low byte first. It then raises the high-byte select, and the upper bits move down onto the lowest lanes. The enable logic combines three inputs: an active-low chip select, a read/convert level and the converter's busy flag. This lets the host read in either of two ways. With a positive read pulse, the previous result appears while the pulse is high. With a negative convert pulse, the result appears once the conversion completes.

Top module: `adc_byte_port`

## Requirements
- R1: After a synchronous active-low reset the held word is zero, so every data lane reads 0 in both steering modes.
- R2: The held word takes `result_i` on the clock edge where `load_i` is 1 and is otherwise unchanged, so repeated reads return the same word even while `result_i` changes.
- R3: All bits of `oe_o` are 1 exactly when `cs_n_i` is 0, `rdcv_i` is 1 and `busy_i` is 1 together, and all are 0 otherwise; the enable follows these inputs in the same cycle.
- R4: While `busy_i` is 0 (conversion in progress) every bit of `oe_o` is 0 whatever the other controls do.
- R5: While `cs_n_i` is 1 every bit of `oe_o` is 0 whatever the other controls do.
- R6: With `hbe_i` 0, `data_o[i]` equals held bit i for every i, so the MSB lands on lane 11 and the LSB on lane 0.
- R7: With `hbe_i` 1, lanes 3..0 carry held bits 11..8, lanes 7..4 are 0, and lanes 11..8 keep carrying held bits 11..8.
- R8: Read-pulse use: with busy high and chip select low, raising `rdcv_i` enables the previously loaded word, and lowering it returns all enables to 0.
- R9: Convert-pulse use: lowering `rdcv_i` clears the enables, they stay 0 while busy is low even if `rdcv_i` returns high, and they come back with the newly loaded word once busy rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| result_i | input | 12 | Conversion word to capture |
| load_i | input | 1 | Capture strobe for `result_i` |
| busy_i | input | 1 | High when idle, low during a conversion |
| cs_n_i | input | 1 | Active-low chip select |
| rdcv_i | input | 1 | Read/convert level |
| hbe_i | input | 1 | High-byte select for split reads |
| data_o | output | 12 | Steered lane values toward the pads |
| oe_o | output | 12 | Per-lane output enable |

## Verification
The bench loads every 12-bit word and reads it in both steering modes. A lane map with a transposed, missing or unforced lane shows up as an arithmetic mismatch on some word. It also sweeps all sixteen combinations of the four control inputs. An enable that ignores one of chip select, read/convert or busy then turns on in a combination where it must float. Separate sequences change `result_i` without a load and walk through both read-pulse and convert-pulse timelines. A register that captures on every cycle returns a changed word. A gate that latches its enable instead of following the current levels keeps driving after read/convert falls or while busy is low.

// File: rtl/adc_port_pkg.sv
// Package: shared types for the converter output port.
// Assumes nothing beyond the parameters passed to the users of these types.
package adc_port_pkg;

    // Lane steering choice made by the high-byte select.
    typedef enum logic {
        LANE_FULL = 1'b0,
        LANE_HIGH = 1'b1
    } lane_mode_e;

    // Control levels that decide whether the lanes drive.
    typedef struct packed {
        logic sel_n;
        logic rdcv;
        logic idle;
    } drive_ctrl_t;

endpackage

// File: rtl/adc_word_hold.sv
// Module: holds the latest conversion word.
// Captures din on a clock edge with load_i high; keeps it otherwise.
// Assumes a synchronous active-low reset that clears the word to zero.
module adc_word_hold #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    logic [WORD_W-1:0] held_q;

    // Capture the result on the strobe, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load_i) begin
            held_q <= din;
        end
    end

    assign dout = held_q;

endmodule

// File: rtl/adc_lane_steer.sv
// Module: maps the held word onto the output lanes.
// Full mode passes bits straight through. High mode moves the top
// HIGH_W bits down onto the lowest lanes and forces the lanes between
// HIGH_W and BYTE_W low. The top lanes keep their own bits.
// Assumes BYTE_W < WORD_W <= 2*BYTE_W.
module adc_lane_steer
    import adc_port_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int BYTE_W = 8
) (
    input  lane_mode_e        mode,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] lanes
);

    localparam int HIGH_W = WORD_W - BYTE_W;

    logic high_sel;
    assign high_sel = (mode == LANE_HIGH);

    // One mux per lane; the lane's position picks its variant.
    for (genvar i = 0; i < WORD_W; i++) begin : g_lane
        if (i < HIGH_W) begin : g_fold
            assign lanes[i] = high_sel ? word[BYTE_W + i] : word[i];
        end else if (i < BYTE_W) begin : g_zero
            assign lanes[i] = high_sel ? 1'b0 : word[i];
        end else begin : g_keep
            assign lanes[i] = word[i];
        end
    end

endmodule

// File: rtl/adc_drive_gate.sv
// Module: builds the per-lane output enables from the control levels.
// The lanes drive only when chip select is low, read/convert is high
// and the converter is idle, all at once. The enable follows the
// levels combinationally, so both read styles come from one gate.
// Assumes the control levels are already synchronous to the chip clock.
module adc_drive_gate
    import adc_port_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  drive_ctrl_t       ctrl,
    output logic [WORD_W-1:0] oe
);

    logic drive_en;

    // Combine the three conditions into a single drive decision.
    always_comb begin
        drive_en = !ctrl.sel_n && ctrl.rdcv && ctrl.idle;
    end

    // Fan the decision out to one enable per lane.
    for (genvar i = 0; i < WORD_W; i++) begin : g_oe
        assign oe[i] = drive_en;
    end

endmodule

// File: rtl/adc_byte_port.sv
// Module: top of the converter output port.
// Holds the last result, steers it for full or split reads and
// decides when the lanes drive. Pads are outside this block.
// Assumes BYTE_W < WORD_W <= 2*BYTE_W and synchronous control inputs.
module adc_byte_port
    import adc_port_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] result_i,
    input  logic              load_i,
    input  logic              busy_i,
    input  logic              cs_n_i,
    input  logic              rdcv_i,
    input  logic              hbe_i,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] oe_o
);

    logic [WORD_W-1:0] held_word;
    lane_mode_e        lane_mode;
    drive_ctrl_t       drv_ctrl;

    // Translate the raw pins into the shared control types.
    always_comb begin
        lane_mode     = hbe_i ? LANE_HIGH : LANE_FULL;
        drv_ctrl.sel_n = cs_n_i;
        drv_ctrl.rdcv  = rdcv_i;
        drv_ctrl.idle  = busy_i;
    end

    adc_word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .din    (result_i),
        .dout   (held_word)
    );

    adc_lane_steer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_steer (
        .mode  (lane_mode),
        .word  (held_word),
        .lanes (data_o)
    );

    adc_drive_gate #(.WORD_W(WORD_W)) u_gate (
        .ctrl (drv_ctrl),
        .oe   (oe_o)
    );

endmodule

// File: rtl/adc_byte_port_chk.sv
// Module: assertion checker for adc_byte_port, attached by bind.
// Watches only the top-level ports.
module adc_byte_port_chk #(
    parameter int WORD_W = 12,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] result_i,
    input logic              load_i,
    input logic              busy_i,
    input logic              cs_n_i,
    input logic              rdcv_i,
    input logic              hbe_i,
    input logic [WORD_W-1:0] data_o,
    input logic [WORD_W-1:0] oe_o
);

    localparam int HIGH_W = WORD_W - BYTE_W;

    // R3: any enabled lane implies all three drive conditions.
    assert_oe_needs_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o != '0) |-> (!cs_n_i && rdcv_i && busy_i));

    // R3: the enables are all equal.
    assert_oe_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o == '0) || (oe_o == '1));

    // R4: busy low floats every lane.
    assert_busy_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (oe_o == '0));

    // R5: chip select high floats every lane.
    assert_cs_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |-> (oe_o == '0));

    // R2: a load shows up in the next cycle in full mode.
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (hbe_i || (data_o == $past(result_i))));

    // R2: without a load and with the mode unchanged the lanes hold.
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((hbe_i != $past(hbe_i)) || $stable(data_o)));

    // R7: the middle lanes are forced low in high mode.
    assert_mid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hbe_i |-> (data_o[BYTE_W-1:HIGH_W] == '0));

    // R7: the lowest lanes repeat the top lanes in high mode.
    assert_fold_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hbe_i |-> (data_o[HIGH_W-1:0] == data_o[WORD_W-1:BYTE_W]));

endmodule

bind adc_byte_port adc_byte_port_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .result_i (result_i),
    .load_i   (load_i),
    .busy_i   (busy_i),
    .cs_n_i   (cs_n_i),
    .rdcv_i   (rdcv_i),
    .hbe_i    (hbe_i),
    .data_o   (data_o),
    .oe_o     (oe_o)
);

// File: tb/sim_adc_byte_port.sv
module sim_adc_byte_port;

    localparam int WORD_W = 12;
    localparam int BYTE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] result_i = '0;
    logic              load_i = 1'b0;
    logic              busy_i = 1'b1;
    logic              cs_n_i = 1'b1;
    logic              rdcv_i = 1'b0;
    logic              hbe_i = 1'b0;
    logic [WORD_W-1:0] data_o;
    logic [WORD_W-1:0] oe_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    adc_byte_port #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .result_i(result_i), .load_i(load_i),
        .busy_i(busy_i), .cs_n_i(cs_n_i), .rdcv_i(rdcv_i), .hbe_i(hbe_i),
        .data_o(data_o), .oe_o(oe_o)
    );

    task automatic check(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] steer(logic [WORD_W-1:0] w, logic hi);
        int top;
        top = (int'(w) >> BYTE_W) & 15;
        if (hi) return WORD_W'((top << BYTE_W) + top);
        return w;
    endfunction

    task automatic load_word(logic [WORD_W-1:0] w);
        @(negedge clk);
        result_i = w;
        load_i   = 1'b1;
        @(negedge clk);
        load_i   = 1'b0;
        #1;
    endtask

    task automatic set_ctrl(logic cs, logic rc, logic bz, logic hb);
        cs_n_i = cs; rdcv_i = rc; busy_i = bz; hbe_i = hb;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state in both modes
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R1 data full", data_o, '0);
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
        check("R1 data high", data_o, '0);

        // R6, R7: every word in both modes
        for (int w = 0; w < (1 << WORD_W); w++) begin
            load_word(WORD_W'(w));
            set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
            check("R6 full lanes", data_o, WORD_W'(w));
            set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
            check("R7 high lanes", data_o, steer(WORD_W'(w), 1'b1));
        end

        // R3, R4, R5: all control combinations on a fixed word
        load_word(12'hA5C);
        for (int c = 0; c < 16; c++) begin
            logic cs, rc, bz, hb;
            logic [WORD_W-1:0] exp_oe;
            {cs, rc, bz, hb} = 4'(c);
            set_ctrl(cs, rc, bz, hb);
            exp_oe = (!cs && rc && bz) ? '1 : '0;
            if (!bz)     check("R4 busy floats", oe_o, '0);
            else if (cs) check("R5 cs floats", oe_o, '0);
            else         check("R3 enable gate", oe_o, exp_oe);
            check("R7 steer under ctrl", data_o, steer(12'hA5C, hb));
        end

        // R2: result changes without a load are not seen
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            result_i = 12'h3C3 ^ WORD_W'(k * 291);
            rdcv_i = ~rdcv_i;
            @(negedge clk);
            rdcv_i = 1'b1;
            #1;
            check("R2 hold without load", data_o, 12'hA5C);
        end

        // R8: read-pulse sequence
        load_word(12'h5A3);
        set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 idle low float", oe_o, '0);
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R8 rise enables", oe_o, '1);
        check("R8 previous word", data_o, 12'h5A3);
        set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 fall floats", oe_o, '0);

        // R9: convert-pulse sequence
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R9 before pulse", oe_o, '1);
        set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 fall floats", oe_o, '0);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 busy keeps float", oe_o, '0);
        load_word(12'h81E);
        check("R9 load while busy", oe_o, '0);
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R9 done enables", oe_o, '1);
        check("R9 new word", data_o, 12'h81E);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule